// File: doc/BRIEF.md
# Cache line fill order generator

This block produces the doubleword byte offsets for a four-beat fill of a 16-byte cache line. A fill always starts with the doubleword that holds the requested data. The three remaining doublewords then follow in one of two orders. The caller pulses a start strobe together with the critical doubleword index (address bits 3..2) and an order select. Each beat is held until a ready input accepts it. The block reports the current byte offset, the beat index, a flag on the final beat and a busy indication.

The two orders suit different memory systems. The interleaved order flips address bits in step with the beat count, which keeps two-bank memory alternating between banks. The wrap order walks upward through the line and wraps at its end, which brings the following opcode in as early as possible. Capturing data and handling the bus protocol are left to the surrounding logic.

Top module: `fill_order_gen`

## Requirements
- R1: A burst presents exactly four beats, and their offsets are 0x0, 0x4, 0x8 and 0xC, each appearing once. Offset bits 1..0 are always zero.
- R2: The first beat of a burst (beat index 0) presents offset `start_dw_i*4`, using the index captured with the accepted start.
- R3: With `mode_i`=0 (interleaved), beat k presents offset `(start_dw XOR k)*4`, so the four possible bursts are 0-4-8-C, 4-0-C-8, 8-C-0-4 and C-8-4-0.
- R4: With `mode_i`=1 (wrap), beat k presents offset `((start_dw+k) mod 4)*4`, so the four possible bursts are 0-4-8-C, 4-8-C-0, 8-C-0-4 and C-0-4-8.
- R5: The beat index and the offset move on only at a clock edge where `ready_i` is high during a burst. At any other edge they keep their values.
- R6: `last_o` is high exactly while beat index 3 is presented. When that beat is accepted with `ready_i`, `busy_o` is low from the next cycle.
- R7: A start strobe seen while `busy_o` is high has no effect on the running burst. This includes the cycle in which the final beat is accepted, and no new burst begins afterwards.
- R8: The order select is captured together with an accepted start. Changing `mode_i` during a burst does not change that burst's offsets.
- R9: In reset and while idle, `busy_o`, `last_o`, `beat_o` and `offset_o` are all zero. The reset is synchronous and active low.
- R10: A start strobe seen while idle sets `busy_o` at the next clock edge, with beat index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for a fill |
| start_dw_i | input | 2 | Index of the critical doubleword (address bits 3..2) |
| mode_i | input | 1 | Order select: 0 interleaved, 1 wrap |
| ready_i | input | 1 | Accepts the beat presented in this cycle |
| busy_o | output | 1 | A burst is in progress |
| offset_o | output | 4 | Byte offset of the current doubleword |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |
| last_o | output | 1 | The current beat is the fourth one |

## Verification
All four start indices are run in both orders, and the two sequences differ for start indices 1 and 3. Those cases separate XOR arithmetic from addition. Random gaps in ready between beats show whether the offset advances on time or holds during a stall. During bursts, the stimulus also drives start strobes carrying a different index and a flipped order select, including one on the cycle the final beat is accepted, to check that capture happens only at an idle start.

// File: rtl/fill_order_pkg.sv
// Shared types for the cache line fill order generator.
// Assumes the two-valued order select maps straight onto the mode input.
package fill_order_pkg;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_WRAP       = 1'b1
    } fill_ord_e;

endpackage

// File: rtl/fill_beat_ctrl.sv
// Burst control for one line fill. It accepts a start while idle and
// captures the critical index and the order. It then counts beats that
// ready accepts and drops busy after the final beat.
// Assumes: start is a single-cycle request; starts seen while busy are dropped.
module fill_beat_ctrl
    import fill_order_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_idx_i,
    input  fill_ord_e        ord_i,
    input  logic             ready_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] beat_o,
    output logic [IDX_W-1:0] base_idx_o,
    output fill_ord_e        ord_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_BEAT = {IDX_W{1'b1}};

    logic accept_start;
    logic accept_beat;

    // Decode the start and beat-acceptance events.
    always_comb begin
        accept_start = start_i && !busy_o;
        accept_beat  = busy_o && ready_i;
        last_o       = busy_o && (beat_o == LAST_BEAT);
    end

    // Busy flag and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            beat_o <= '0;
        end else if (accept_start) begin
            busy_o <= 1'b1;
            beat_o <= '0;
        end else if (accept_beat) begin
            if (beat_o == LAST_BEAT) begin
                busy_o <= 1'b0;
                beat_o <= '0;
            end else begin
                beat_o <= beat_o + 1'b1;
            end
        end
    end

    // Capture the critical index and order once per burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_idx_o <= '0;
            ord_o      <= ORD_INTERLEAVE;
        end else if (accept_start) begin
            base_idx_o <= start_idx_i;
            ord_o      <= ord_i;
        end
    end

endmodule

// File: rtl/fill_offset_calc.sv
// Maps (critical index, beat index, order) to a doubleword byte offset.
// Interleaved order XORs the beat into the index; wrap order adds it modulo
// the line size. Purely combinational; forces zero while idle.
module fill_offset_calc
    import fill_order_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int WORD_W = 2
) (
    input  logic                    busy_i,
    input  logic [IDX_W-1:0]        base_idx_i,
    input  logic [IDX_W-1:0]        beat_i,
    input  fill_ord_e               ord_i,
    output logic [IDX_W+WORD_W-1:0] offset_o
);
    logic [IDX_W-1:0] xor_idx;
    logic [IDX_W-1:0] add_idx;
    logic [IDX_W-1:0] sel_idx;

    // Build both candidate indices bit by bit; the add wraps at line end.
    for (genvar b = 0; b < IDX_W; b++) begin : g_xor
        assign xor_idx[b] = base_idx_i[b] ^ beat_i[b];
    end
    assign add_idx = base_idx_i + beat_i;

    // Pick the order's index and scale it to a byte offset.
    always_comb begin
        sel_idx  = (ord_i == ORD_WRAP) ? add_idx : xor_idx;
        offset_o = busy_i ? {sel_idx, {WORD_W{1'b0}}} : '0;
    end

endmodule

// File: rtl/fill_order_gen.sv
// Top of the cache line fill order generator: one controller and one
// offset calculator. The defaults give four doubleword beats per 16-byte line.
module fill_order_gen
    import fill_order_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int WORD_W = 2,
    localparam int OFS_W = IDX_W + WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_dw_i,
    input  logic             mode_i,
    input  logic             ready_i,
    output logic             busy_o,
    output logic [OFS_W-1:0] offset_o,
    output logic [IDX_W-1:0] beat_o,
    output logic             last_o
);
    logic [IDX_W-1:0] base_idx;
    fill_ord_e        ord_q;
    fill_ord_e        ord_in;

    // Turn the raw mode bit into the order type.
    always_comb ord_in = fill_ord_e'(mode_i);

    fill_beat_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_idx_i(start_dw_i),
        .ord_i      (ord_in),
        .ready_i    (ready_i),
        .busy_o     (busy_o),
        .beat_o     (beat_o),
        .base_idx_o (base_idx),
        .ord_o      (ord_q),
        .last_o     (last_o)
    );

    fill_offset_calc #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_calc (
        .busy_i    (busy_o),
        .base_idx_i(base_idx),
        .beat_i    (beat_o),
        .ord_i     (ord_q),
        .offset_o  (offset_o)
    );

endmodule

// File: rtl/fill_order_chk.sv
// Port-level checker for fill_order_gen, attached by bind.
module fill_order_chk #(
    parameter int IDX_W  = 2,
    parameter int WORD_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [IDX_W-1:0]        start_dw_i,
    input logic                    ready_i,
    input logic                    busy_o,
    input logic [IDX_W+WORD_W-1:0] offset_o,
    input logic [IDX_W-1:0]        beat_o,
    input logic                    last_o
);
    AST_OFFSET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        offset_o[WORD_W-1:0] == '0); // R1

    AST_FIRST_BEAT_CRITICAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (offset_o == {$past(start_dw_i), {WORD_W{1'b0}}})); // R2

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ready_i) |=> ($stable(beat_o) && $stable(offset_o) && busy_o)); // R5

    AST_ADVANCE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ready_i && !last_o) |=> (busy_o && beat_o == $past(beat_o) + 1'b1)); // R5

    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && ready_i) |=> !busy_o); // R6

    AST_LAST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> busy_o); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (offset_o == '0 && beat_o == '0 && !last_o)); // R9

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && beat_o == '0)); // R10

endmodule

bind fill_order_gen fill_order_chk #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .start_dw_i(start_dw_i),
    .ready_i   (ready_i),
    .busy_o    (busy_o),
    .offset_o  (offset_o),
    .beat_o    (beat_o),
    .last_o    (last_o)
);

// File: tb/sim_fill_order_gen.sv
// Bench: directed bursts over every start index in both orders, then random
// bursts with stalls and stray starts. Inputs change on the falling edge and
// outputs are sampled on the falling edge.
module sim_fill_order_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] start_dw_i = '0;
    logic       mode_i = 1'b0;
    logic       ready_i = 1'b0;
    logic       busy_o;
    logic [3:0] offset_o;
    logic [1:0] beat_o;
    logic       last_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fill_order_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_dw_i(start_dw_i),
        .mode_i(mode_i), .ready_i(ready_i), .busy_o(busy_o), .offset_o(offset_o),
        .beat_o(beat_o), .last_o(last_o)
    );

    function automatic int exp_off(int sd, bit md, int k);
        if (md) return ((sd + k) % 4) * 4;
        return ((sd ^ k) & 3) * 4;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One burst. stall_max bounds the random ready gaps; noise drives stray
    // starts and mode flips during the burst; late_start strobes on final accept.
    task automatic burst(int sd, bit md, int stall_max, bit noise, bit late_start);
        int seen = 0;
        @(negedge clk);
        start_i = 1'b1; start_dw_i = 2'(sd); mode_i = md; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy", int'(busy_o), 1);
        for (int k = 0; k < 4; k++) begin
            int stalls = (stall_max > 0) ? int'($urandom % (stall_max + 1)) : 0;
            int e = exp_off(sd, md, k);
            chk(int'(beat_o) == k, "R5 beat", int'(beat_o), k);
            if (k == 0) chk(int'(offset_o) == e, "R2 first", int'(offset_o), e);
            if (md) chk(int'(offset_o) == e, "R4 wrap", int'(offset_o), e);
            else    chk(int'(offset_o) == e, "R3 interleave", int'(offset_o), e);
            chk(last_o == (k == 3), "R6 last", int'(last_o), int'(k == 3));
            seen |= 1 << (int'(offset_o) / 4);
            for (int s = 0; s < stalls; s++) begin
                ready_i = 1'b0;
                if (noise) begin
                    start_i = 1'b1; start_dw_i = 2'(sd + 1); mode_i = ~md;
                end
                @(negedge clk);
                start_i = 1'b0;
                chk(int'(offset_o) == e, "R5 stall hold", int'(offset_o), e);
                chk(int'(beat_o) == k && !noise || int'(beat_o) == k,
                    "R7 stray start", int'(beat_o), k);
            end
            ready_i = 1'b1;
            if (noise) mode_i = ~md;
            if (late_start && k == 3) begin
                start_i = 1'b1; start_dw_i = 2'(sd + 2);
            end
            @(negedge clk);
            ready_i = 1'b0; start_i = 1'b0;
        end
        chk(busy_o == 1'b0, "R6 end", int'(busy_o), 0);
        chk(seen == 15, "R1 coverage", seen, 15);
        chk(offset_o == 4'h0 && beat_o == 2'd0 && !last_o, "R9 idle",
            int'(offset_o), 0);
        if (late_start) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R7 late start", int'(busy_o), 0);
        end
        if (noise) chk(offset_o == 4'h0, "R8 idle after noisy burst", int'(offset_o), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && offset_o == 4'h0 && beat_o == 2'd0 && !last_o,
            "R9 reset", int'(busy_o), 0);
        rst_n = 1'b1;
        for (int md = 0; md < 2; md++)
            for (int sd = 0; sd < 4; sd++)
                burst(sd, md[0], 0, 1'b0, 1'b0);
        burst(1, 1'b0, 2, 1'b1, 1'b0);  // R8: mode flipped mid-burst
        burst(3, 1'b1, 2, 1'b1, 1'b1);  // R7: start on final accept
        burst(1, 1'b1, 1, 1'b1, 1'b1);
        for (int n = 0; n < 60; n++)
            burst(int'($urandom % 4), 1'($urandom), 3, 1'($urandom), 1'($urandom));
        // Reset in mid-burst returns to idle.
        @(negedge clk);
        start_i = 1'b1; start_dw_i = 2'd2;
        @(negedge clk);
        start_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0 && offset_o == 4'h0, "R9 mid reset", int'(busy_o), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule